// File: doc/BRIEF.md
# Floating-Point Status Register with Aliased Views

This block keeps the eight-bit floating-point control and status word of a processor core. The word holds two fields: five sticky exception flags in bits [4:0] and a three-bit rounding-mode field in bits [7:5]. Software reaches the word through a control-register access port. A two-bit selector picks one of three views: the flags alone, the rounding mode alone, or the whole word. Each partial view reads its field right-justified. A write through a partial view merges the new field into the stored word and leaves the other field untouched.

The floating-point datapath reports new exceptions on a separate five-bit input. Those bits are ORed into the flag field on every clock edge, so a flag stays set until software clears it. When a legal control-register write lands in the same cycle, the write wins and the raised flags of that cycle are dropped. A request with selector value 0 reports an error, reads zero and changes nothing. The block does not check whether a rounding-mode value is legal, and it contains no arithmetic.

Top module: `fpstat_reg`

## Requirements
- R1: While reset is asserted and right after it is released, the stored word is 0x00.
- R2: Selector encoding is 1 = flags view, 2 = rounding-mode view, 3 = full view. A request with selector 0 drives `acc_err` high and `acc_rdata` to zero in the same cycle. A legal request keeps `acc_err` low.
- R3: A write through the flags view (selector 1) sets bits [4:0] to `acc_wdata[4:0]` and keeps bits [7:5].
- R4: A write through the rounding-mode view (selector 2) sets bits [7:5] to `acc_wdata[2:0]` and keeps bits [4:0].
- R5: A write through the full view (selector 3) stores `acc_wdata[7:0]`. Higher data bits have no effect.
- R6: Reads are combinational. The flags view returns the word's bits [4:0] in `acc_rdata[4:0]`, the rounding-mode view returns bits [7:5] in `acc_rdata[2:0]`, and the full view returns the whole word in `acc_rdata[7:0]`. All other read bits are zero.
- R7: When no legal write takes place, each clock edge ORs `raise_flags` into bits [4:0] and leaves bits [7:5] unchanged.
- R8: A legal write in the same cycle as nonzero `raise_flags` takes priority. The next word is exactly the value the write defines, and the raised flags of that cycle are lost.
- R9: A write request with selector 0 does not change the stored word, apart from the OR of `raise_flags` required by R7.
- R10: With `acc_req` low, `acc_rdata` is zero and `acc_err` is low, whatever `acc_wr`, `acc_sel` and `acc_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | View selector (1 flags, 2 rounding mode, 3 full) |
| acc_wdata | input | DATA_W | Write data; only the low bits of the chosen view are used |
| acc_rdata | output | DATA_W | Read data of the selected view, zero-extended |
| acc_err | output | 1 | Request used an illegal selector |
| raise_flags | input | 5 | Exception flags raised by the datapath this cycle |
| stat_o | output | 8 | Current stored word, for the datapath |

## Verification
Directed writes through each view use data whose unused upper bits and untouched fields are all ones. A write that leaks outside its field, or that shifts the field into the wrong place, therefore changes a visible bit. Cycles that combine a write with raised flags, and cycles that raise flags with no write, separate the write-priority rule from the sticky OR. Selector 0 and idle cycles carry busy data, so they show whether illegal or absent requests have any effect. A long stretch of mixed pseudo-random traffic is then compared, cycle by cycle, against an arithmetic model that splits the word by division and remainder.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int STAT_W = FLAG_W + RM_W;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_FLAGS = 2'd1,
    VIEW_RMODE = 2'd2,
    VIEW_FULL  = 2'd3
  } view_e;

  typedef struct packed {
    logic [RM_W-1:0]   rm;
    logic [FLAG_W-1:0] flags;
  } stat_t;

  // Next stored word after a legal write through view v.
  function automatic stat_t merge_view(stat_t cur, view_e v, logic [STAT_W-1:0] wlow);
    stat_t nxt;
    nxt = cur;
    case (v)
      VIEW_FLAGS: nxt.flags = wlow[FLAG_W-1:0];
      VIEW_RMODE: nxt.rm    = wlow[RM_W-1:0];
      VIEW_FULL:  nxt       = stat_t'(wlow);
      default:    nxt       = cur;
    endcase
    return nxt;
  endfunction

  // Right-justified content of view v.
  function automatic logic [STAT_W-1:0] read_view(stat_t cur, view_e v);
    logic [STAT_W-1:0] r;
    r = '0;
    case (v)
      VIEW_FLAGS: r[FLAG_W-1:0] = cur.flags;
      VIEW_RMODE: r[RM_W-1:0]   = cur.rm;
      VIEW_FULL:  r             = cur;
      default:    r             = '0;
    endcase
    return r;
  endfunction

  // Sticky accumulation of datapath exceptions.
  function automatic stat_t accrue(stat_t cur, logic [FLAG_W-1:0] raised);
    stat_t nxt;
    nxt       = cur;
    nxt.flags = cur.flags | raised;
    return nxt;
  endfunction

endpackage

// File: rtl/fpstat_decode.sv
module fpstat_decode
  import fpstat_pkg::*;
(
  input  logic             req,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  output view_e            view,
  output logic             sel_legal,
  output logic             wr_hit,
  output logic             rd_hit,
  output logic             err
);

  always_comb begin
    view      = view_e'(sel);
    sel_legal = (view != VIEW_NONE);
    rd_hit    = req && sel_legal;
    wr_hit    = req && wr && sel_legal;
    err       = req && !sel_legal;
  end

endmodule

// File: rtl/fpstat_store.sv
module fpstat_store
  import fpstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  view_e             view,
  input  logic [STAT_W-1:0] wlow,
  input  logic [FLAG_W-1:0] raised,
  output stat_t             stat_q
);

  stat_t stat_d;

  always_comb begin
    if (wr_hit) stat_d = merge_view(stat_q, view, wlow);
    else        stat_d = accrue(stat_q, raised);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

endmodule

// File: rtl/fpstat_readmux.sv
module fpstat_readmux
  import fpstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_hit,
  input  view_e             view,
  input  stat_t             stat,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] sel_bits;

  always_comb begin
    sel_bits = rd_hit ? read_view(stat, view) : '0;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, sel_bits};
    end else begin : g_nopad
      assign rdata = sel_bits[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
  import fpstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_req,
  input  logic                     acc_wr,
  input  logic [SEL_W-1:0]         acc_sel,
  input  logic [DATA_W-1:0]        acc_wdata,
  output logic [DATA_W-1:0]        acc_rdata,
  output logic                     acc_err,
  input  logic [FLAG_W-1:0]        raise_flags,
  output logic [STAT_W-1:0]        stat_o
);

  // Named internal events, brought out for the checker.
  view_e view;
  logic  sel_legal;
  logic  wr_hit;
  logic  rd_hit;
  stat_t stat_q;

  fpstat_decode u_dec (
    .req       (acc_req),
    .wr        (acc_wr),
    .sel       (acc_sel),
    .view      (view),
    .sel_legal (sel_legal),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .err       (acc_err)
  );

  fpstat_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .view   (view),
    .wlow   (acc_wdata[STAT_W-1:0]),
    .raised (raise_flags),
    .stat_q (stat_q)
  );

  fpstat_readmux #(.DATA_W(DATA_W)) u_rmux (
    .rd_hit (rd_hit),
    .view   (view),
    .stat   (stat_q),
    .rdata  (acc_rdata)
  );

  assign stat_o = stat_q;

endmodule

// File: rtl/fpstat_chk.sv
module fpstat_chk
  import fpstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_wr,
  input logic [SEL_W-1:0]  acc_sel,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_err,
  input logic [FLAG_W-1:0] raise_flags,
  input logic [STAT_W-1:0] stat_o,
  input logic              wr_hit,
  input logic              sel_legal
);

  // R2: an error response never carries data
  a_r2_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == '0));

  // R2: error only on a real request with an illegal selector
  a_r2_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_req && !sel_legal));

  // R3: flags-view write keeps the rounding mode
  a_r3_rm_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_sel == 2'd1) |=>
      (stat_o[STAT_W-1:FLAG_W] == $past(stat_o[STAT_W-1:FLAG_W])));

  // R4: rounding-mode write keeps the flags
  a_r4_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_sel == 2'd2) |=>
      (stat_o[FLAG_W-1:0] == $past(stat_o[FLAG_W-1:0])));

  // R5: full-view write stores the low data byte
  a_r5_full_store: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && acc_sel == 2'd3) |=> (stat_o == $past(acc_wdata[STAT_W-1:0])));

  // R6: flags-view read has zero upper bits
  a_r6_flags_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_sel == 2'd1) |-> (acc_rdata[DATA_W-1:FLAG_W] == '0));

  // R7: without a write, flags accrue and rounding mode holds
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (stat_o == {$past(stat_o[STAT_W-1:FLAG_W]),
                            $past(stat_o[FLAG_W-1:0]) | $past(raise_flags)}));

  // R10: idle port returns nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (acc_rdata == '0 && !acc_err));

endmodule

bind fpstat_reg fpstat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_req     (acc_req),
  .acc_wr      (acc_wr),
  .acc_sel     (acc_sel),
  .acc_wdata   (acc_wdata),
  .acc_rdata   (acc_rdata),
  .acc_err     (acc_err),
  .raise_flags (raise_flags),
  .stat_o      (stat_o),
  .wr_hit      (wr_hit),
  .sel_legal   (sel_legal)
);

// File: tb/fpstat_reg_tb.sv
module fpstat_reg_tb;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_req = 1'b0;
  logic          acc_wr = 1'b0;
  logic [1:0]    acc_sel = 2'd0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic          acc_err;
  logic [4:0]    raise_flags = 5'd0;
  logic [7:0]    stat_o;

  int n_run = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpstat_reg #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .raise_flags(raise_flags), .stat_o(stat_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One access cycle: check the combinational read, then the stored word.
  task automatic step(input bit req, input bit wr, input int sel,
                      input logic [31:0] wd, input int rs, input string tag);
    int exp_rd;
    bit exp_err;
    @(negedge clk);
    acc_req = req; acc_wr = wr; acc_sel = sel[1:0];
    acc_wdata = wd; raise_flags = rs[4:0];
    #1;
    exp_rd = 0; exp_err = 0;
    if (req) begin
      if (sel == 0)      exp_err = 1;
      else if (sel == 1) exp_rd = model % 32;
      else if (sel == 2) exp_rd = model / 32;
      else               exp_rd = model;
    end
    check({tag, " R6/R10 rdata"}, acc_rdata, exp_rd);
    check({tag, " R2 err"}, acc_err, exp_err);
    @(posedge clk);
    if (req && wr && sel != 0) begin
      if (sel == 1)      model = (model / 32) * 32 + int'(wd % 32);
      else if (sel == 2) model = int'(wd % 8) * 32 + model % 32;
      else               model = int'(wd % 256);
    end else begin
      model = (model / 32) * 32 + ((model % 32) | rs);
    end
    #1;
    check({tag, " word"}, stat_o, model);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", stat_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 3, 32'h0, 0, "R1 read after reset");

    step(1, 1, 3, 32'hDEAD_BEEF, 0, "R5 full write");
    step(1, 0, 3, 32'h0, 0, "R6 full read");
    step(1, 0, 1, 32'hFFFF_FFFF, 0, "R6 flags read");
    step(1, 0, 2, 32'hFFFF_FFFF, 0, "R6 rm read");
    step(1, 1, 1, 32'hFFFF_FFE3, 0, "R3 flags write");
    step(1, 1, 2, 32'hFFFF_FFFA, 0, "R4 rm write");
    step(1, 1, 3, 32'h0000_0100, 0, "R5 upper bits ignored");
    step(0, 0, 0, 32'h0, 5'b00101, "R7 raise");
    step(0, 0, 0, 32'h0, 5'b10000, "R7 raise sticky");
    step(0, 0, 0, 32'h0, 5'b00000, "R7 hold");
    step(1, 1, 1, 32'h0, 5'b11111, "R8 flags write beats raise");
    step(1, 1, 2, 32'h5, 5'b01010, "R8 rm write beats raise");
    step(1, 1, 3, 32'h41, 5'b11111, "R8 full write beats raise");
    step(1, 1, 0, 32'hFFFF_FFFF, 0, "R9 sel0 write");
    step(1, 1, 0, 32'h0, 5'b00010, "R9 sel0 write with raise");
    step(1, 0, 0, 32'h0, 0, "R2 sel0 read");
    step(0, 1, 3, 32'hFFFF_FFFF, 0, "R10 idle write ignored");
    step(0, 1, 1, 32'h0, 0, "R10 idle flags write ignored");

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[2], r[4:3], $urandom,
           (r[7:5] == 3'd0) ? r[12:8] : 0, "R7 mixed traffic");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule